// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Hourly Chime

This block keeps the time of day as six packed-decimal (8421 BCD) digits: hours, minutes and seconds, each as a tens digit and a ones digit, over a 24-hour day. It runs entirely on one system clock. A one-cycle `tick` enable, normally asserted once per second by an external prescaler, advances the seconds. Each field passes a carry to the next when it wraps, and the hours wrap from 23 back to 00.

Two push-buttons are used to set the time. While `set_mode` is high, the carries that normally feed the minutes and the hours are cut off. Each button, once debounced, then advances its own field by one step per press. The seconds keep counting. A registered `chime` output is high during the last ten seconds of every hour, so that an external sounder can be driven from it.

Top module: `bcd_clock_core`

## Requirements
- R1: While `rst` is high, all six digits go to 0 and `chime` goes low at every clock edge.
- R2: When `tick` is high, the seconds advance by one. When `tick` is low, the seconds hold.
- R3: A ones digit that passes 9 goes to 0 and carries into its tens digit. The seconds and the minutes both count 00 to 59 and carry into the next field as they wrap to 00.
- R4: The hours count 00 to 23. A tick at 23:59:59 with `set_mode` low gives 00:00:00, so 86400 ticks from 00:00:00 return the time to 00:00:00.
- R5: Every ones digit is at most 9. Each seconds and minutes tens digit is at most 5. The hours value is at most 23.
- R6: While `set_mode` is high, the seconds keep counting but no carry from the seconds reaches the minutes and no carry from the minutes reaches the hours. If a manual step and a carry arrive for the same field at the same time, the manual step wins.
- R7: With `set_mode` high, each debounced press of `btn_min` advances the minutes by one. Advancing from 59 gives 00 and leaves the hours unchanged.
- R8: With `set_mode` high, each debounced press of `btn_hr` advances the hours by one. Advancing from 23 gives 00.
- R9: With `set_mode` low, the buttons have no effect on the time.
- R10: A button must be seen high for DEB_CYCLES consecutive clocks (after a two-flop synchronizer) before it counts. A shorter press has no effect, and a long press gives exactly one step.
- R11: `chime` is high exactly while the displayed minutes equal 59 and the displayed seconds are 50 through 59. It changes on the same edge as the digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable that advances the seconds |
| set_mode | input | 1 | High while the time is being set |
| btn_min | input | 1 | Raw minutes-advance button |
| btn_hr | input | 1 | Raw hours-advance button |
| sec_ones | output | 4 | Seconds ones digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes ones digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours ones digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| chime | output | 1 | High during the last ten seconds of each hour |

## Verification
The assertions check the following on every cycle:
- the digit ranges;
- that the seconds hold without a tick;
- the seconds ones wrap;
- the day rollover;
- the chime window against the digits;
- that the minutes and hours stay frozen in set mode unless their own debounced step fires;
- the reset values.

Some behaviour only the bench scenarios can show:
- that a press shorter than the debounce window is lost;
- that a long press gives exactly one step;
- that the buttons do nothing outside set mode;
- that a manual minute wrap leaves the hours alone.

The bench shows these by comparing the time against its behavioural model and by running a whole day of ticks.

// File: rtl/clk_core_pkg.sv
package clk_core_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
  localparam bcd_t SIX_TENS_MAX = 4'd5;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic press
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic          s1, s2, level;
  logic [CW-1:0] cnt;
  logic          flip;

  assign flip = (s2 != level) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      cnt   <= '0;
      press <= 1'b0;
    end else begin
      s1    <= raw;
      s2    <= s1;
      press <= flip && s2;
      if (s2 == level) begin
        cnt <= '0;
      end else if (flip) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcd_sixty_field.sv
module bcd_sixty_field
  import clk_core_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output bcd_t ones,
  output bcd_t tens,
  output bcd_t nxt_ones,
  output bcd_t nxt_tens,
  output logic carry
);
  logic ones_wrap, tens_wrap;

  assign ones_wrap = (ones == BCD_MAX);
  assign tens_wrap = (tens == SIX_TENS_MAX);
  assign carry     = adv && ones_wrap && tens_wrap;

  always_comb begin
    nxt_ones = ones;
    nxt_tens = tens;
    if (adv) begin
      if (ones_wrap) begin
        nxt_ones = '0;
        nxt_tens = tens_wrap ? '0 : tens + 4'd1;
      end else begin
        nxt_ones = ones + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones <= '0;
      tens <= '0;
    end else begin
      ones <= nxt_ones;
      tens <= nxt_tens;
    end
  end
endmodule

// File: rtl/bcd_hour_field.sv
module bcd_hour_field
  import clk_core_pkg::*;
#(
  parameter int HOURS = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output bcd_t ones,
  output bcd_t tens
);
  localparam int   LAST   = HOURS - 1;
  localparam bcd_t LAST_T = 4'(LAST / 10);
  localparam bcd_t LAST_O = 4'(LAST % 10);

  logic at_last;
  assign at_last = (tens == LAST_T) && (ones == LAST_O);

  always_ff @(posedge clk) begin
    if (rst) begin
      ones <= '0;
      tens <= '0;
    end else if (adv) begin
      if (at_last) begin
        ones <= '0;
        tens <= '0;
      end else if (ones == BCD_MAX) begin
        ones <= '0;
        tens <= tens + 4'd1;
      end else begin
        ones <= ones + 4'd1;
      end
    end
  end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import clk_core_pkg::*;
#(
  parameter int DEB_CYCLES = 16,
  parameter int HOURS      = 24,
  parameter int CHIME_LEAD = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       set_mode,
  input  logic       btn_min,
  input  logic       btn_hr,
  output logic [3:0] sec_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] min_ones,
  output logic [3:0] min_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] hr_tens,
  output logic       chime
);
  localparam int       NBTN        = 2;
  localparam logic [6:0] CHIME_FROM = 7'(60 - CHIME_LEAD);

  logic [NBTN-1:0] raw_btn, btn_press;
  logic            min_man, hr_man;
  logic            sec_carry, min_carry;
  logic            min_adv, hr_adv;
  bcd_t            sec_no, sec_nt, min_no, min_nt;
  logic [6:0]      nxt_sec_val;

  assign raw_btn = {btn_hr, btn_min};

  for (genvar g = 0; g < NBTN; g++) begin : g_deb
    btn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_btn[g]),
      .press (btn_press[g])
    );
  end

  assign min_man = set_mode && btn_press[0];
  assign hr_man  = set_mode && btn_press[1];
  assign min_adv = set_mode ? min_man : sec_carry;
  assign hr_adv  = set_mode ? hr_man  : min_carry;

  bcd_sixty_field u_sec (
    .clk(clk), .rst(rst), .adv(tick),
    .ones(sec_ones), .tens(sec_tens),
    .nxt_ones(sec_no), .nxt_tens(sec_nt), .carry(sec_carry)
  );

  bcd_sixty_field u_min (
    .clk(clk), .rst(rst), .adv(min_adv),
    .ones(min_ones), .tens(min_tens),
    .nxt_ones(min_no), .nxt_tens(min_nt), .carry(min_carry)
  );

  bcd_hour_field #(.HOURS(HOURS)) u_hr (
    .clk(clk), .rst(rst), .adv(hr_adv),
    .ones(hr_ones), .tens(hr_tens)
  );

  assign nxt_sec_val = 7'(sec_nt) * 7'd10 + 7'(sec_no);

  always_ff @(posedge clk) begin
    if (rst) chime <= 1'b0;
    else     chime <= (min_nt == 4'd5) && (min_no == 4'd9) && (nxt_sec_val >= CHIME_FROM);
  end
endmodule

// File: rtl/clock_core_chk.sv
module clock_core_chk #(
  parameter int HOURS = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       set_mode,
  input logic       min_man,
  input logic       hr_man,
  input logic [3:0] sec_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] min_ones,
  input logic [3:0] min_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] hr_tens,
  input logic       chime
);
  logic [7:0] hr_val;
  assign hr_val = 8'(hr_tens) * 8'd10 + 8'(hr_ones);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sec_ones == 0 && sec_tens == 0 && min_ones == 0 && min_tens == 0 &&
             hr_ones == 0 && hr_tens == 0 && !chime));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({sec_tens, sec_ones}));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_ones == 4'd9) |=> (sec_ones == 4'd0));

  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !set_mode && hr_val == 8'(HOURS - 1) && min_tens == 4'd5 && min_ones == 4'd9 &&
     sec_tens == 4'd5 && sec_ones == 4'd9) |=> (hr_val == 8'd0 && min_tens == 0 && min_ones == 0));

  // R5
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    sec_ones <= 4'd9 && sec_tens <= 4'd5 && min_ones <= 4'd9 && min_tens <= 4'd5 &&
    hr_ones <= 4'd9 && hr_val < 8'(HOURS));

  // R6
  min_block_chk: assert property (@(posedge clk) disable iff (rst)
    (set_mode && !min_man) |=> $stable({min_tens, min_ones}));

  // R6
  hr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (set_mode && !hr_man) |=> $stable({hr_tens, hr_ones}));

  // R11
  chime_window_chk: assert property (@(posedge clk) disable iff (rst)
    chime == (min_tens == 4'd5 && min_ones == 4'd9 && sec_tens == 4'd5));
endmodule

bind bcd_clock_core clock_core_chk #(.HOURS(HOURS)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode),
  .min_man(min_man), .hr_man(hr_man),
  .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones), .min_tens(min_tens),
  .hr_ones(hr_ones), .hr_tens(hr_tens), .chime(chime)
);

// File: tb/tb_bcd_clock_core.sv
module tb_bcd_clock_core;
  localparam int DEB = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, set_mode = 1'b0, btn_min = 1'b0, btn_hr = 1'b0;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
  logic chime;

  bcd_clock_core #(.DEB_CYCLES(DEB)) dut (
    .clk(clk), .rst(rst), .tick(tick), .set_mode(set_mode),
    .btn_min(btn_min), .btn_hr(btn_hr),
    .sec_ones(sec_ones), .sec_tens(sec_tens), .min_ones(min_ones), .min_tens(min_tens),
    .hr_ones(hr_ones), .hr_tens(hr_tens), .chime(chime)
  );

  always #2 clk = ~clk;

  int m_s = 0, m_m = 0, m_h = 0;
  int hold_min = 0, hold_hr = 0;
  bit prev_min = 0, prev_hr = 0;
  bit cmp_en = 0;
  int checks = 0, errors = 0;

  // behavioural reference: time as integers, buttons as held-length counters
  always @(posedge clk) begin
    if (rst) begin
      m_s = 0; m_m = 0; m_h = 0; hold_min = 0; hold_hr = 0;
    end else begin
      if (tick) begin
        m_s = m_s + 1;
        if (m_s == 60) begin
          m_s = 0;
          if (!set_mode) begin
            m_m = m_m + 1;
            if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; end
          end
        end
      end
      if (btn_min) hold_min = hold_min + 1;
      else begin
        if (prev_min && hold_min >= DEB && set_mode) m_m = (m_m + 1) % 60;
        hold_min = 0;
      end
      if (btn_hr) hold_hr = hold_hr + 1;
      else begin
        if (prev_hr && hold_hr >= DEB && set_mode) m_h = (m_h + 1) % 24;
        hold_hr = 0;
      end
    end
    prev_min = btn_min;
    prev_hr  = btn_hr;
  end

  function automatic int cur_s(); return sec_tens * 10 + sec_ones; endfunction
  function automatic int cur_m(); return min_tens * 10 + min_ones; endfunction
  function automatic int cur_h(); return hr_tens * 10 + hr_ones; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R2 R3 R4 R5 R11)
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk(sec_ones <= 9 && sec_tens <= 5 && min_ones <= 9 && min_tens <= 5 && hr_ones <= 9,
          "R5 digit range", cur_s(), m_s);
      chk(cur_s() == m_s && cur_m() == m_m && cur_h() == m_h, "R2 R3 R4 time",
          cur_h() * 10000 + cur_m() * 100 + cur_s(), m_h * 10000 + m_m * 100 + m_s);
      chk(chime == (m_m == 59 && m_s >= 50), "R11 chime", int'(chime), int'(m_m == 59 && m_s >= 50));
    end
  end

  task automatic press(input bit which_hr, input int len);
    cmp_en = 0;
    if (which_hr) btn_hr = 1; else btn_min = 1;
    repeat (len) @(negedge clk);
    btn_hr = 0; btn_min = 0;
    repeat (3 * DEB + 4) @(negedge clk);
    cmp_en = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int h0, m0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_h() == 0 && cur_m() == 0 && cur_s() == 0 && !chime, "R1 reset",
        cur_h() * 10000 + cur_m() * 100 + cur_s(), 0);
    rst = 0;
    cmp_en = 1;
    // R4 full day of ticks
    tick = 1;
    repeat (86400) @(negedge clk);
    chk(cur_h() == 0 && cur_m() == 0 && cur_s() == 0, "R4 day rollover",
        cur_h() * 10000 + cur_m() * 100 + cur_s(), 0);
    repeat (3700) @(negedge clk);
    // R2 sparse ticks
    for (int i = 0; i < 300; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
    end
    // R6 set mode blocks carries
    h0 = cur_h(); m0 = cur_m();
    set_mode = 1; tick = 1;
    repeat (150) @(negedge clk);
    chk(cur_m() == m0, "R6 minutes frozen", cur_m(), m0);
    chk(cur_h() == h0, "R6 hours frozen", cur_h(), h0);
    tick = 0;
    // R7 minutes manual advance with wrap
    m0 = cur_m();
    for (int i = m0; i < 59; i++) press(0, 3 * DEB);
    chk(cur_m() == 59, "R7 minutes to 59", cur_m(), 59);
    press(0, 3 * DEB);
    chk(cur_m() == 0, "R7 minute wrap", cur_m(), 0);
    chk(cur_h() == h0, "R7 hours untouched", cur_h(), h0);
    // R8 hours manual advance with wrap
    for (int i = h0; i < 23; i++) press(1, 3 * DEB);
    chk(cur_h() == 23, "R8 hours to 23", cur_h(), 23);
    press(1, 3 * DEB);
    chk(cur_h() == 0, "R8 hour wrap", cur_h(), 0);
    // R9 buttons ignored outside set mode
    set_mode = 0;
    m0 = cur_m(); h0 = cur_h();
    press(0, 3 * DEB);
    press(1, 3 * DEB);
    chk(cur_m() == m0, "R9 min button ignored", cur_m(), m0);
    chk(cur_h() == h0, "R9 hr button ignored", cur_h(), h0);
    // R10 short press rejected, long press gives one step
    set_mode = 1;
    press(0, DEB - 2);
    chk(cur_m() == m0, "R10 short press", cur_m(), m0);
    press(0, 10 * DEB);
    chk(cur_m() == (m0 + 1) % 60, "R10 single step", cur_m(), (m0 + 1) % 60);
    // R11 chime reached through manual minutes then ticks
    for (int i = cur_m(); i < 59; i++) press(0, 3 * DEB);
    tick = 1;
    repeat (70) @(negedge clk);
    tick = 0;
    set_mode = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule